// File: doc/BRIEF.md
# Four-Way Data Cache Line State and Replacement Controller

This block holds the tag and coherence state of every line in a four-way set-associative data cache and decides where new lines go. Each CPU access carries its own mode flag. In copyback mode a line can be invalid, clean-valid or dirty. In write-through mode a line can only be invalid or valid. A lookup reports the hit way and whether that line is dirty. A miss that must allocate picks a victim way and raises a fill request. The fill stays pending until memory signals that the line has arrived.

Victim choice takes the lowest-numbered invalid way first. When the set is full, a two-bit rotating pointer kept per set makes the choice. A dirty victim is parked in a single-entry push buffer. That entry is offered for writeback only once the pending fill has finished. Line-targeted invalidate and push commands, and bus snoop probes, remove lines. Every snoop is compared against the tags of the addressed set and against the push buffer. Data storage and the external bus protocol belong to the surrounding cache.

Top module: `dcache_line_ctrl`

## Requirements
- R1: After reset every line is invalid, so no probe hits and the victim for any set is way 0. No fill or writeback is requested, and both request and command inputs are accepted.
- R2: `hit` is high in the same cycle as a request whose tag matches a non-invalid line of the addressed set. `hit_way` names that way. No two live lines of one set ever share a tag.
- R3: In copyback mode a read miss or a write miss raises `fill_req` in the cycle after acceptance, with the set, tag and way of the new line. After the cycle in which `fill_done` is high, the line is valid for a read miss and dirty for a write miss.
- R4: When the addressed set holds at least one invalid line, the victim is the lowest-numbered invalid way, and the rotating pointer of that set does not move.
- R5: When all four lines of the set are valid or dirty, the victim is the way held in that set's rotating pointer. The pointer then increments modulo 4.
- R6: In copyback mode a write hit turns a valid line dirty, and a read hit leaves the state as it was. `hit_dirty` reports a dirty hit line.
- R7: In write-through mode a read miss allocates a valid line through a normal fill. A write miss raises no fill and changes no line.
- R8: In write-through mode read hits and write hits leave the line state unchanged, so a valid line never becomes dirty.
- R9: A dirty victim moves into the push buffer when its miss is accepted. `wb_req` stays low while a fill is pending and rises once the fill completes. It shows the victim's set and tag, and it drops after `wb_done`.
- R10: An invalidate command (`cmd_push` = 0) makes the addressed line invalid with no writeback. A push command (`cmd_push` = 1) on a dirty line loads the push buffer, which raises `wb_req`, and then invalidates the line. A push command on a valid line just invalidates it.
- R11: A snoop that matches a live line of its set raises `snoop_hit` with `snoop_way` and invalidates that line. A snoop that matches the set and tag held in a full push buffer raises `snoop_pb_hit`.
- R12: While the push buffer is full, `req_ready` is low for a miss whose victim is dirty, and `cmd_ready` is low for a push command on a dirty line. Each rises in the cycle after `wb_done` drains the buffer.
- R13: In any cycle with `snoop_valid` high, `req_ready` and `cmd_ready` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU access present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wthru | input | 1 | 1 = write-through mode, 0 = copyback mode |
| req_set | input | SET_W | Set index of the access |
| req_tag | input | TAG_W | Tag of the access |
| req_ready | output | 1 | Access accepted at the next clock edge |
| hit | output | 1 | Access tag matches a live line |
| hit_dirty | output | 1 | Matching line is dirty |
| hit_way | output | 2 | Way of the matching line |
| victim_way | output | 2 | Way chosen for allocation in the addressed set |
| fill_req | output | 1 | Line fill pending |
| fill_set | output | SET_W | Set of the pending fill |
| fill_tag | output | TAG_W | Tag of the pending fill |
| fill_way | output | 2 | Way of the pending fill |
| fill_done | input | 1 | Memory has delivered the pending line |
| wb_req | output | 1 | Push buffer entry awaiting writeback |
| wb_set | output | SET_W | Set of the entry to write back |
| wb_tag | output | TAG_W | Tag of the entry to write back |
| wb_done | input | 1 | Writeback of the push buffer entry finished |
| cmd_valid | input | 1 | Line command present |
| cmd_push | input | 1 | 1 = push, 0 = invalidate |
| cmd_set | input | SET_W | Set of the commanded line |
| cmd_way | input | 2 | Way of the commanded line |
| cmd_ready | output | 1 | Command accepted at the next clock edge |
| snoop_valid | input | 1 | Snoop probe present |
| snoop_set | input | SET_W | Set index of the probe |
| snoop_tag | input | TAG_W | Tag of the probe |
| snoop_hit | output | 1 | Probe matches a live cache line |
| snoop_way | output | 2 | Way of the matching line |
| snoop_pb_hit | output | 1 | Probe matches the push buffer entry |

## Verification
Some rules are checked in every cycle. Live tags in a set stay unique. The lowest free way wins over the rotating pointer. The pointer steps exactly once for each eviction of a live line. A landed fill gets the state its miss called for. A write hit in copyback mode leaves a dirty line. A snoop hit leaves an invalid line. The push buffer is never loaded while full and never offered for writeback during a fill. The bench's scenarios are needed to show the rest. Write-through lines never turn dirty. Invalidate and push commands differ in what they write back. Stalls release when the buffer drains. A push-buffer snoop match reports the right entry. All of this is shown over long mixed sequences compared against an independent state model.

// File: rtl/cl_pkg.sv
package cl_pkg;

    typedef enum logic [1:0] {
        LS_INV   = 2'b00,
        LS_VAL   = 2'b01,
        LS_DIRTY = 2'b10
    } line_st_e;

    function automatic logic is_live(input logic [1:0] st);
        return st != LS_INV;
    endfunction

    // state after a hit: only a copyback write promotes a clean line
    function automatic logic [1:0] after_hit(input logic [1:0] st,
                                             input logic wr,
                                             input logic wthru);
        if (wr && !wthru && st == LS_VAL) return LS_DIRTY;
        return st;
    endfunction

    // state given to a freshly filled line
    function automatic logic [1:0] fill_state(input logic dirty);
        return dirty ? LS_DIRTY : LS_VAL;
    endfunction

endpackage

// File: rtl/cl_tag_match.sv
module cl_tag_match import cl_pkg::*; #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0][1:0]        way_st,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        match,
    output logic [WAY_W-1:0]            match_way
);

    logic [WAYS-1:0] hv;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_cmp
            assign hv[g] = is_live(way_st[g]) && (way_tag[g] == probe_tag);
        end
    endgenerate

    always_comb begin
        match_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hv[i]) match_way = WAY_W'(i);
        end
    end

    assign match = |hv;

    // R2: live tags within one set never collide
    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hv));

endmodule

// File: rtl/cl_victim.sv
module cl_victim import cl_pkg::*; #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WAYS-1:0][1:0]  way_st,
    input  logic [WAY_W-1:0]      rr_ptr,
    output logic [WAY_W-1:0]      pick_way,
    output logic [1:0]            pick_st
);

    logic [WAYS-1:0] free;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_free
            assign free[g] = (way_st[g] == LS_INV);
        end
    endgenerate

    always_comb begin
        pick_way = rr_ptr;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (free[i]) pick_way = WAY_W'(i);
        end
        pick_st = way_st[pick_way];
    end

    // R4: a free way is chosen and no lower way is free
    a_r4_lowest_free: assert property (@(posedge clk) disable iff (rst)
        (|free) |-> (free[pick_way] &&
                     ((free & ((WAYS'(1) << pick_way) - WAYS'(1))) == '0)));

endmodule

// File: rtl/cl_push_buf.sv
module cl_push_buf #(
    parameter int SET_W = 2,
    parameter int TAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SET_W-1:0]  load_set,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic              hold,
    input  logic              wb_done,
    input  logic              probe_en,
    input  logic [SET_W-1:0]  probe_set,
    input  logic [TAG_W-1:0]  probe_tag,
    output logic              full,
    output logic              wb_req,
    output logic [SET_W-1:0]  wb_set,
    output logic [TAG_W-1:0]  wb_tag,
    output logic              probe_hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            wb_set <= '0;
            wb_tag <= '0;
        end else if (load) begin
            full   <= 1'b1;
            wb_set <= load_set;
            wb_tag <= load_tag;
        end else if (wb_req && wb_done) begin
            full   <= 1'b0;
        end
    end

    assign wb_req    = full && !hold;
    assign probe_hit = probe_en && full && (wb_set == probe_set) && (wb_tag == probe_tag);

    // R9: the single entry is never overwritten
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        load |-> !full);

    // R9: a completed writeback empties the entry
    a_r9_drain_empties: assert property (@(posedge clk) disable iff (rst)
        (wb_req && wb_done) |=> !full);

endmodule

// File: rtl/dcache_line_ctrl.sv
module dcache_line_ctrl import cl_pkg::*; #(
    parameter int SET_W = 2,
    parameter int TAG_W = 8,
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wthru,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_ready,
    output logic              hit,
    output logic              hit_dirty,
    output logic [WAY_W-1:0]  hit_way,
    output logic [WAY_W-1:0]  victim_way,
    output logic              fill_req,
    output logic [SET_W-1:0]  fill_set,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [WAY_W-1:0]  fill_way,
    input  logic              fill_done,
    output logic              wb_req,
    output logic [SET_W-1:0]  wb_set,
    output logic [TAG_W-1:0]  wb_tag,
    input  logic              wb_done,
    input  logic              cmd_valid,
    input  logic              cmd_push,
    input  logic [SET_W-1:0]  cmd_set,
    input  logic [WAY_W-1:0]  cmd_way,
    output logic              cmd_ready,
    input  logic              snoop_valid,
    input  logic [SET_W-1:0]  snoop_set,
    input  logic [TAG_W-1:0]  snoop_tag,
    output logic              snoop_hit,
    output logic [WAY_W-1:0]  snoop_way,
    output logic              snoop_pb_hit
);

    localparam int NUM_SETS = 1 << SET_W;

    // line storage
    logic [NUM_SETS-1:0][WAYS-1:0][1:0]       st_q;
    logic [NUM_SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [NUM_SETS-1:0][WAY_W-1:0]           rr_q;

    // pending fill
    logic              filling_q;
    logic              fill_dirty_q;
    logic [SET_W-1:0]  fill_set_q;
    logic [TAG_W-1:0]  fill_tag_q;
    logic [WAY_W-1:0]  fill_way_q;

    // lookup results
    logic              rq_hit;
    logic [WAY_W-1:0]  rq_way;
    logic              sn_match;
    logic [WAY_W-1:0]  sn_way;
    logic [WAY_W-1:0]  vic_way;
    logic [1:0]        vic_st;

    // control
    logic              need_alloc;
    logic              vic_dirty;
    logic              req_go;
    logic              cmd_go;
    logic [1:0]        cmd_line_st;
    logic              cmd_dirty;
    logic              pb_full;
    logic              pb_load;
    logic [SET_W-1:0]  pb_ld_set;
    logic [TAG_W-1:0]  pb_ld_tag;

    cl_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_match (
        .clk       (clk),
        .rst       (rst),
        .way_st    (st_q[req_set]),
        .way_tag   (tag_q[req_set]),
        .probe_tag (req_tag),
        .match     (rq_hit),
        .match_way (rq_way)
    );

    cl_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snoop_match (
        .clk       (clk),
        .rst       (rst),
        .way_st    (st_q[snoop_set]),
        .way_tag   (tag_q[snoop_set]),
        .probe_tag (snoop_tag),
        .match     (sn_match),
        .match_way (sn_way)
    );

    cl_victim #(.WAYS(WAYS)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .way_st   (st_q[req_set]),
        .rr_ptr   (rr_q[req_set]),
        .pick_way (vic_way),
        .pick_st  (vic_st)
    );

    always_comb begin
        need_alloc  = req_valid && !rq_hit && !(req_write && req_wthru);
        vic_dirty   = (vic_st == LS_DIRTY);
        cmd_line_st = st_q[cmd_set][cmd_way];
        cmd_dirty   = (cmd_line_st == LS_DIRTY);

        req_ready = !filling_q && !snoop_valid && !cmd_valid &&
                    !(need_alloc && vic_dirty && pb_full);
        cmd_ready = !filling_q && !snoop_valid &&
                    !(cmd_push && cmd_dirty && pb_full);

        req_go = req_valid && req_ready;
        cmd_go = cmd_valid && cmd_ready;

        pb_load   = (req_go && need_alloc && vic_dirty) ||
                    (cmd_go && cmd_push && cmd_dirty);
        pb_ld_set = cmd_go ? cmd_set : req_set;
        pb_ld_tag = cmd_go ? tag_q[cmd_set][cmd_way] : tag_q[req_set][vic_way];
    end

    cl_push_buf #(.SET_W(SET_W), .TAG_W(TAG_W)) u_push_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (pb_load),
        .load_set  (pb_ld_set),
        .load_tag  (pb_ld_tag),
        .hold      (filling_q),
        .wb_done   (wb_done),
        .probe_en  (snoop_valid),
        .probe_set (snoop_set),
        .probe_tag (snoop_tag),
        .full      (pb_full),
        .wb_req    (wb_req),
        .wb_set    (wb_set),
        .wb_tag    (wb_tag),
        .probe_hit (snoop_pb_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            tag_q        <= '0;
            rr_q         <= '0;
            filling_q    <= 1'b0;
            fill_dirty_q <= 1'b0;
            fill_set_q   <= '0;
            fill_tag_q   <= '0;
            fill_way_q   <= '0;
        end else begin
            if (snoop_valid && sn_match)
                st_q[snoop_set][sn_way] <= LS_INV;

            if (cmd_go)
                st_q[cmd_set][cmd_way] <= LS_INV;

            if (req_go && rq_hit) begin
                st_q[req_set][rq_way] <= after_hit(st_q[req_set][rq_way], req_write, req_wthru);
            end else if (req_go && need_alloc) begin
                st_q[req_set][vic_way] <= LS_INV;
                filling_q    <= 1'b1;
                fill_dirty_q <= req_write;
                fill_set_q   <= req_set;
                fill_tag_q   <= req_tag;
                fill_way_q   <= vic_way;
                if (is_live(vic_st))
                    rr_q[req_set] <= rr_q[req_set] + WAY_W'(1);
            end

            if (filling_q && fill_done) begin
                st_q[fill_set_q][fill_way_q]  <= fill_state(fill_dirty_q);
                tag_q[fill_set_q][fill_way_q] <= fill_tag_q;
                filling_q <= 1'b0;
            end
        end
    end

    assign hit        = req_valid && rq_hit;
    assign hit_dirty  = hit && (st_q[req_set][rq_way] == LS_DIRTY);
    assign hit_way    = rq_way;
    assign victim_way = vic_way;
    assign fill_req   = filling_q;
    assign fill_set   = fill_set_q;
    assign fill_tag   = fill_tag_q;
    assign fill_way   = fill_way_q;
    assign snoop_hit  = snoop_valid && sn_match;
    assign snoop_way  = sn_way;

    // R5: replacing a live line steps that set's pointer by one
    a_r5_rr_step: assert property (@(posedge clk) disable iff (rst)
        (req_go && need_alloc && is_live(vic_st)) |=>
            (rr_q[$past(req_set)] == $past(rr_q[req_set]) + WAY_W'(1)));

    // R3: a finished fill leaves its line live with the requested state
    a_r3_fill_lands: assert property (@(posedge clk) disable iff (rst)
        (filling_q && fill_done) |=>
            (st_q[$past(fill_set_q)][$past(fill_way_q)] ==
             ($past(fill_dirty_q) ? LS_DIRTY : LS_VAL)));

    // R9: writeback is never offered while a fill is outstanding
    a_r9_wb_after_fill: assert property (@(posedge clk) disable iff (rst)
        filling_q |-> !wb_req);

    // R6: a copyback write hit leaves the line dirty
    a_r6_write_hit_dirty: assert property (@(posedge clk) disable iff (rst)
        (req_go && rq_hit && req_write && !req_wthru) |=>
            (st_q[$past(req_set)][$past(rq_way)] == LS_DIRTY));

    // R7: a write-through write miss starts no fill
    a_r7_wt_write_no_fill: assert property (@(posedge clk) disable iff (rst)
        (req_go && !rq_hit && req_write && req_wthru && !filling_q) |=> !filling_q);

    // R11: a snoop hit leaves the line invalid
    a_r11_snoop_clears: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && sn_match) |=>
            (st_q[$past(snoop_set)][$past(sn_way)] == LS_INV));

endmodule

// File: tb/test_dcache_line_ctrl.sv
module test_dcache_line_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 0, req_write = 0, req_wthru = 0;
    logic [1:0] req_set = 0;
    logic [7:0] req_tag = 0;
    logic       req_ready, hit, hit_dirty;
    logic [1:0] hit_way, victim_way;
    logic       fill_req;
    logic [1:0] fill_set, fill_way;
    logic [7:0] fill_tag;
    logic       fill_done = 0;
    logic       wb_req;
    logic [1:0] wb_set;
    logic [7:0] wb_tag;
    logic       wb_done = 0;
    logic       cmd_valid = 0, cmd_push = 0;
    logic [1:0] cmd_set = 0, cmd_way = 0;
    logic       cmd_ready;
    logic       snoop_valid = 0;
    logic [1:0] snoop_set = 0;
    logic [7:0] snoop_tag = 0;
    logic       snoop_hit, snoop_pb_hit;
    logic [1:0] snoop_way;

    always #4 clk = ~clk;

    dcache_line_ctrl i_dcache_line_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_wthru(req_wthru),
        .req_set(req_set), .req_tag(req_tag), .req_ready(req_ready),
        .hit(hit), .hit_dirty(hit_dirty), .hit_way(hit_way), .victim_way(victim_way),
        .fill_req(fill_req), .fill_set(fill_set), .fill_tag(fill_tag), .fill_way(fill_way),
        .fill_done(fill_done),
        .wb_req(wb_req), .wb_set(wb_set), .wb_tag(wb_tag), .wb_done(wb_done),
        .cmd_valid(cmd_valid), .cmd_push(cmd_push), .cmd_set(cmd_set), .cmd_way(cmd_way),
        .cmd_ready(cmd_ready),
        .snoop_valid(snoop_valid), .snoop_set(snoop_set), .snoop_tag(snoop_tag),
        .snoop_hit(snoop_hit), .snoop_way(snoop_way), .snoop_pb_hit(snoop_pb_hit)
    );

    // reference model: 0 invalid, 1 valid, 2 dirty
    int         m_st  [4][4];
    logic [7:0] m_tag [4][4];
    int         m_rr  [4];
    bit         pb_full = 0;
    int         pb_set = 0;
    logic [7:0] pb_tag = 0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic drain();
        chk("R9", "wb_req before drain", int'(wb_req), int'(pb_full));
        if (pb_full) begin
            chk("R9", "wb_set", int'(wb_set), pb_set);
            chk("R9", "wb_tag", int'(wb_tag), int'(pb_tag));
            wb_done = 1;
            @(negedge clk);
            wb_done = 0;
            #1;
            pb_full = 0;
            chk("R9", "wb_req after drain", int'(wb_req), 0);
        end
    endtask

    task automatic do_access(input int s, input logic [7:0] t, input bit wr, input bit wt);
        bit hitm = 0; int hw = 0; int vw = -1; bit alloc; bit vdirty; bit from_rr;
        logic [7:0] oldtag;
        for (int w = 0; w < 4; w++)
            if (m_st[s][w] != 0 && m_tag[s][w] == t) begin hitm = 1; hw = w; end
        alloc = !hitm && !(wr && wt);
        for (int w = 3; w >= 0; w--) if (m_st[s][w] == 0) vw = w;
        from_rr = (vw < 0);
        if (from_rr) vw = m_rr[s];
        vdirty = (m_st[s][vw] == 2);
        oldtag = m_tag[s][vw];

        @(negedge clk);
        req_valid = 1; req_set = 2'(s); req_tag = t; req_write = wr; req_wthru = wt;
        #1;
        chk("R2", "hit", int'(hit), int'(hitm));
        if (hitm) begin
            chk("R2", "hit_way", int'(hit_way), hw);
            chk(wt ? "R8" : "R6", "hit_dirty", int'(hit_dirty), int'(m_st[s][hw] == 2));
        end
        if (alloc) chk(from_rr ? "R5" : "R4", "victim_way", int'(victim_way), vw);
        if (alloc && vdirty && pb_full) begin
            chk("R12", "req_ready stalled", int'(req_ready), 0);
            drain();
        end
        chk("R12", "req_ready", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 0;
        #1;
        if (hitm) begin
            if (wr && !wt && m_st[s][hw] == 1) m_st[s][hw] = 2;
            chk(wt ? "R8" : "R6", "no fill on hit", int'(fill_req), 0);
        end else if (alloc) begin
            if (m_st[s][vw] != 0) m_rr[s] = (m_rr[s] + 1) % 4;
            if (vdirty) begin pb_full = 1; pb_set = s; pb_tag = oldtag; end
            m_st[s][vw] = 0;
            chk(wt ? "R7" : "R3", "fill_req", int'(fill_req), 1);
            chk("R3", "fill_way", int'(fill_way), vw);
            chk("R3", "fill_set", int'(fill_set), s);
            chk("R3", "fill_tag", int'(fill_tag), int'(t));
            chk("R9", "wb_req during fill", int'(wb_req), 0);
            repeat (s % 3) @(negedge clk);
            fill_done = 1;
            @(negedge clk);
            fill_done = 0;
            #1;
            m_st[s][vw] = wr ? 2 : 1;
            m_tag[s][vw] = t;
            chk("R3", "fill_req cleared", int'(fill_req), 0);
            chk("R9", "wb_req after fill", int'(wb_req), int'(pb_full));
        end else begin
            chk("R7", "no fill on wt write miss", int'(fill_req), 0);
        end
    endtask

    task automatic do_cmd(input bit push, input int s, input int w);
        bit dirty = (m_st[s][w] == 2);
        @(negedge clk);
        cmd_valid = 1; cmd_push = push; cmd_set = 2'(s); cmd_way = 2'(w);
        #1;
        if (push && dirty && pb_full) begin
            chk("R12", "cmd_ready stalled", int'(cmd_ready), 0);
            drain();
        end
        chk("R10", "cmd_ready", int'(cmd_ready), 1);
        @(negedge clk);
        cmd_valid = 0;
        #1;
        if (push && dirty) begin pb_full = 1; pb_set = s; pb_tag = m_tag[s][w]; end
        m_st[s][w] = 0;
        chk("R10", "wb_req after command", int'(wb_req), int'(pb_full));
        if (push && dirty) chk("R10", "pushed tag", int'(wb_tag), int'(pb_tag));
    endtask

    task automatic do_snoop(input int s, input logic [7:0] t);
        bit hm = 0; int hw = 0; bit pbm;
        for (int w = 0; w < 4; w++)
            if (m_st[s][w] != 0 && m_tag[s][w] == t) begin hm = 1; hw = w; end
        pbm = pb_full && pb_set == s && pb_tag == t;
        @(negedge clk);
        snoop_valid = 1; snoop_set = 2'(s); snoop_tag = t;
        #1;
        chk("R11", "snoop_hit", int'(snoop_hit), int'(hm));
        if (hm) chk("R11", "snoop_way", int'(snoop_way), hw);
        chk("R11", "snoop_pb_hit", int'(snoop_pb_hit), int'(pbm));
        chk("R13", "req_ready during snoop", int'(req_ready), 0);
        chk("R13", "cmd_ready during snoop", int'(cmd_ready), 0);
        @(negedge clk);
        snoop_valid = 0;
        #1;
        if (hm) m_st[s][hw] = 0;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int s = 0; s < 4; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin m_st[s][w] = 0; m_tag[s][w] = 0; end
        end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1", "fill_req", int'(fill_req), 0);
        chk("R1", "wb_req", int'(wb_req), 0);
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "cmd_ready", int'(cmd_ready), 1);
        for (int s = 0; s < 4; s++) begin
            req_valid = 1; req_set = 2'(s); req_tag = 8'h00; req_write = 0; req_wthru = 0;
            #1;
            chk("R1", "hit after reset", int'(hit), 0);
            chk("R1", "victim after reset", int'(victim_way), 0);
            req_valid = 0;
            #1;
        end

        // invalid-first then rotating replacement in set 0
        for (int k = 1; k <= 6; k++) do_access(0, 8'(k), 0, 0);
        do_access(0, 8'd3, 1, 0);
        do_access(0, 8'd3, 0, 0);
        // write-through behaviour in set 1
        do_access(1, 8'd9, 1, 1);
        do_access(1, 8'd9, 0, 1);
        do_access(1, 8'd9, 1, 1);
        do_access(1, 8'd9, 0, 1);
        // dirty set 2, then overflow the push buffer
        for (int k = 1; k <= 6; k++) do_access(2, 8'(k), 1, 0);
        do_snoop(2, pb_tag);
        do_access(2, 8'd3, 1, 0);
        do_cmd(1, 2, 2);
        do_cmd(1, 2, 3);
        drain();
        do_cmd(0, 0, 0);
        do_cmd(1, 0, 1);

        for (int n = 0; n < 1500; n++) begin
            int op, s;
            logic [7:0] t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = int'(lfsr[2:0]);
            s  = int'(lfsr[4:3]);
            t  = 8'(1 + (int'(lfsr[9:5]) % 6));
            case (op)
                0, 1, 2: do_access(s, t, lfsr[10], lfsr[11] && lfsr[12]);
                3:       do_access(s, t, 1'b1, 1'b0);
                4:       do_cmd(lfsr[13], s, int'(lfsr[15:14]));
                5:       do_snoop(s, t);
                6:       if (lfsr[11]) drain(); else do_access(s, t, 1'b0, 1'b1);
                default: do_access(s, t, 1'b0, 1'b0);
            endcase
        end
        drain();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule